// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host presents one request at a time on a valid/ready handshake: an 18-bit word address, a write flag, 16 bits of write data and two byte-lane enables. The controller then runs a complete access on the RAM pins and returns read data with a one-cycle valid strobe. The RAM side consists of a registered address, two chip selects of opposite polarity, a write strobe, an output enable and two active-low lane enables. The data bus is split into an input, an output and a per-lane drive enable, and the pad cells sit outside the block.

Every analog interval is a nanosecond parameter: read access, write pulse, data setup, cycle time and output turn-off. Each one is rounded up to whole clock periods. A read holds the output enable low for the access count and then samples the bus. A write raises the chip select one cycle ahead of the write strobe, so the write ends on the rising edge of the strobe with the address unchanged. Between accesses the RAM is left deselected, so it drops into standby by itself.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset, and in every cycle where `reqReady` is high, the pins sit in standby: `memCe1N`=1, `memCe2`=0, `memByteN`=2'b11, `memWeN`=1, `memOeN`=1, `memDqOutEn`=0. `rspValid` is 0 after reset.
- R2: A read accepted on a clock edge keeps `memCe1N`=0, `memCe2`=1, `memOeN`=0 and `memWeN`=1 for RD cycles. With the defaults (10 ns clock, 55 ns access) RD is 6. `rspValid` is high in the cycle after those RD cycles.
- R3: Lane bit 0 of `reqByteEn` selects data bits 7:0 and drives `memByteN[0]` low. Lane bit 1 selects bits 15:8 and drives `memByteN[1]` low. In `rspData`, an unrequested lane reads as zero. A requested lane carries the RAM word as it was after all earlier writes.
- R4: A write holds `memWeN` low for exactly WP cycles, which is 4 with the defaults (40 ns pulse, 20 ns data setup). For the whole pulse `memOeN` stays high, the chip is selected, and `memDqOutEn` equals the requested lanes.
- R5: `memAddr` does not change while `memWeN` is low.
- R6: A byte write changes only its own lane in the RAM. The other lane is neither driven nor altered.
- R7: `memDqOutEn` is never nonzero while `memOeN` is low. Driving starts no earlier than TURN cycles (2 with the defaults, from 20 ns) after `memOeN` rises.
- R8: `reqReady` is low from the accepting edge until the access ends. A read stays busy for exactly RD cycles. A write stays busy for at least the 55 ns cycle time, and for at least one setup cycle plus WP plus one recovery cycle.
- R9: `rspValid` is a single-cycle pulse and appears only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Lane enables, bit 0 = bits 7:0 |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 16 | Read data, unrequested lanes zero |
| memAddr | output | 18 | RAM address |
| memCe1N | output | 1 | Active-low chip select |
| memCe2 | output | 1 | Active-high chip select |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memByteN | output | 2 | Active-low lane enables, bit 1 = upper |
| memDqOut | output | 16 | Data toward the RAM |
| memDqOutEn | output | 2 | Per-lane pad drive enable |
| memDqIn | input | 16 | Data from the RAM |

## Verification
The main function is exercised with several request patterns. Reads of addresses that were never written show the reset contents of the model RAM. Word writes followed by reads check the address path and the data path. Lower and upper byte writes into the same word show whether lane masking is applied, both in the RAM and in `rspData`. A read placed directly before a write tests the turnaround gap. Addresses at both ends of the range, with alternating bit patterns, catch stuck or swapped address and data bits. A pseudo-random mix of reads, writes and lane masks then catches ordering faults. The RAM model returns inverted data until the access time has passed, so a controller that samples too early is caught by a data mismatch rather than by luck.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } ctrlState_e;

  // Strobes from control to datapath; pin fields describe the next cycle.
  typedef struct packed {
    logic load;     // accept request this cycle
    logic capture;  // sample read bus at the coming edge
    logic select;   // chip selected next cycle
    logic readEn;   // output enable next cycle
    logic writeEn;  // write strobe next cycle
    logic driveEn;  // drive data pins next cycle
  } pinStrobe_t;

  function automatic int cyclesFor(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int WP_CYC   = 4,
  parameter int REC_CYC  = 1,
  parameter int TURN_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output pinStrobe_t strobe
);

  localparam int CNT_MAX = maxInt(RD_CYC, maxInt(WP_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int TURN_W  = $clog2(TURN_CYC + 2);

  ctrlState_e        state, nextState;
  logic [CNT_W-1:0]  cnt, nextCnt;
  logic [TURN_W-1:0] turnCnt;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            nextState = ST_WSETUP;
          end else begin
            nextState = ST_READ;
            nextCnt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - CNT_W'(1);
      end
      ST_WSETUP: begin
        if (turnCnt == '0) begin
          nextState = ST_WPULSE;
          nextCnt   = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (cnt == '0) begin
          nextState = ST_WREC;
          nextCnt   = CNT_W'(REC_CYC - 1);
        end else begin
          nextCnt = cnt - CNT_W'(1);
        end
      end
      ST_WREC: begin
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - CNT_W'(1);
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      turnCnt <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      if (state == ST_READ && cnt == '0)
        turnCnt <= TURN_W'(TURN_CYC);
      else if (turnCnt != '0)
        turnCnt <= turnCnt - TURN_W'(1);
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe.load    = (state == ST_IDLE) && reqValid;
    strobe.capture = (state == ST_READ) && (cnt == '0);
    strobe.select  = (nextState != ST_IDLE);
    strobe.readEn  = (nextState == ST_READ);
    strobe.writeEn = (nextState == ST_WPULSE);
    strobe.driveEn = (nextState == ST_WPULSE) || (nextState == ST_WREC);
  end

  // R7
  turn_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WPULSE) |-> (turnCnt == '0));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  pinStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LANES*8-1:0]  reqWdata,
  input  logic [LANES-1:0]    reqByteEn,
  output logic                rspValid,
  output logic [LANES*8-1:0]  rspData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCe1N,
  output logic                memCe2,
  output logic                memWeN,
  output logic                memOeN,
  output logic [LANES-1:0]    memByteN,
  output logic [LANES*8-1:0]  memDqOut,
  output logic [LANES-1:0]    memDqOutEn,
  input  logic [LANES*8-1:0]  memDqIn
);

  localparam int DATA_W = LANES * 8;

  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  laneQ;
  logic [LANES-1:0]  laneSel;

  assign laneSel  = strobe.load ? reqByteEn : laneQ;
  assign memDqOut = wdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr <= '0;
      wdataQ  <= '0;
      laneQ   <= '0;
    end else if (strobe.load) begin
      memAddr <= reqAddr;
      wdataQ  <= reqWdata;
      laneQ   <= reqByteEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCe1N    <= 1'b1;
      memCe2     <= 1'b0;
      memWeN     <= 1'b1;
      memOeN     <= 1'b1;
      memByteN   <= '1;
      memDqOutEn <= '0;
      rspValid   <= 1'b0;
    end else begin
      memCe1N    <= !strobe.select;
      memCe2     <= strobe.select;
      memWeN     <= !strobe.writeEn;
      memOeN     <= !strobe.readEn;
      memByteN   <= strobe.select ? ~laneSel : '1;
      memDqOutEn <= strobe.driveEn ? laneSel : '0;
      rspValid   <= strobe.capture;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)
        rspData[i*8 +: 8] <= '0;
      else if (strobe.capture)
        rspData[i*8 +: 8] <= laneQ[i] ? memDqIn[i*8 +: 8] : 8'h00;
    end
  end

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOutEn != '0) |-> memOeN);

  // R4
  write_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCe1N && memCe2 && (memDqOutEn == ~memByteN)));

  // R1
  standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    memCe1N |-> (!memCe2 && (memByteN == '1) && memWeN && memOeN && (memDqOutEn == '0)));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int LANES       = 2,
  parameter int CLK_NS      = 10,
  parameter int T_ACCESS_NS = 55,
  parameter int T_RCYCLE_NS = 55,
  parameter int T_WPULSE_NS = 40,
  parameter int T_DSETUP_NS = 20,
  parameter int T_WCYCLE_NS = 55,
  parameter int T_HIZ_NS    = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [LANES*8-1:0]  reqWdata,
  input  logic [LANES-1:0]    reqByteEn,
  output logic                rspValid,
  output logic [LANES*8-1:0]  rspData,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCe1N,
  output logic                memCe2,
  output logic                memWeN,
  output logic                memOeN,
  output logic [LANES-1:0]    memByteN,
  output logic [LANES*8-1:0]  memDqOut,
  output logic [LANES-1:0]    memDqOutEn,
  input  logic [LANES*8-1:0]  memDqIn
);

  localparam int RD_CYC = maxInt(1, maxInt(cyclesFor(T_ACCESS_NS, CLK_NS),
                                           cyclesFor(T_RCYCLE_NS, CLK_NS)));
  localparam int WP_CYC = maxInt(1, maxInt(cyclesFor(T_WPULSE_NS, CLK_NS),
                                           cyclesFor(T_DSETUP_NS, CLK_NS)));
  localparam int REC_CYC  = maxInt(1, cyclesFor(T_WCYCLE_NS, CLK_NS) - WP_CYC - 1);
  localparam int TURN_CYC = cyclesFor(T_HIZ_NS, CLK_NS);

  pinStrobe_t strobe;

  sram_ctrl_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqByteEn (reqByteEn),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .memAddr   (memAddr),
    .memCe1N   (memCe1N),
    .memCe2    (memCe2),
    .memWeN    (memWeN),
    .memOeN    (memOeN),
    .memByteN  (memByteN),
    .memDqOut  (memDqOut),
    .memDqOutEn(memDqOutEn),
    .memDqIn   (memDqIn)
  );

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int T_ACC  = 55;
  localparam int T_WP   = 40;
  localparam int T_DS   = 20;
  localparam int T_CYC  = 55;
  localparam int T_HZ   = 20;
  localparam int RD     = (T_ACC + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int WP     = ((T_WP > T_DS ? T_WP : T_DS) + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int CYC    = (T_CYC + CLK_PERIOD - 1) / CLK_PERIOD;

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic        reqReady;
  logic        reqWrite = 0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic [17:0] memAddr;
  logic        memCe1N, memCe2, memWeN, memOeN;
  logic [1:0]  memByteN;
  logic [15:0] memDqOut;
  logic [1:0]  memDqOutEn;
  logic [15:0] memDqIn = '0;

  sram_async_ctrl #(.CLK_NS(CLK_PERIOD)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqByteEn(reqByteEn), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN),
    .memOeN(memOeN), .memByteN(memByteN), .memDqOut(memDqOut),
    .memDqOutEn(memDqOutEn), .memDqIn(memDqIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checkCnt = 0;
  int failCnt  = 0;
  int cycCnt   = 0;
  bit done     = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycCnt, act, exp);
    end
  endtask

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // Behavioural RAM model with timing rule checks
  logic [15:0] ramArr [int];
  logic [15:0] shadow [int];
  int          rdAge = 0, wrCnt = 0, oeHighCnt = 100;
  bit          prevRd = 0, prevWr = 0;
  logic [17:0] prevAddr = '0, wrAddr = '0;
  logic [1:0]  wrBe = '0;
  logic [15:0] wrData = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      rdAge = 0; wrCnt = 0; prevRd = 0; prevWr = 0; oeHighCnt = 100;
      memDqIn = '0;
    end else begin
      bit sel, rdCond, wrCond;
      logic [15:0] cur;
      sel    = !memCe1N && memCe2;
      rdCond = sel && !memOeN && memWeN && (memByteN != 2'b11);
      if (rdCond && prevRd && memAddr == prevAddr) rdAge++;
      else rdAge = rdCond ? 1 : 0;
      cur = ramArr.exists(int'(memAddr)) ? ramArr[int'(memAddr)] : 16'h0000;
      for (int i = 0; i < 2; i++) begin
        if (rdCond && !memByteN[i])
          memDqIn[i*8 +: 8] = (rdAge * CLK_PERIOD >= T_ACC) ? cur[i*8 +: 8] : ~cur[i*8 +: 8];
        else
          memDqIn[i*8 +: 8] = 8'hA5;
      end
      prevRd = rdCond;
      prevAddr = memAddr;

      if (memOeN) oeHighCnt++; else oeHighCnt = 0;
      if (memDqOutEn != 2'b00)
        check(memOeN && ((oeHighCnt - 1) * CLK_PERIOD >= T_HZ), "R7",
              32'(oeHighCnt), 32'(T_HZ / CLK_PERIOD + 1));

      wrCond = sel && !memWeN;
      if (wrCond) begin
        if (!prevWr) begin
          wrAddr = memAddr; wrCnt = 1;
        end else begin
          wrCnt++;
          check(memAddr == wrAddr, "R5", 32'(memAddr), 32'(wrAddr));
        end
        check(memOeN && (memDqOutEn == ~memByteN), "R4 R6",
              {memOeN, 29'(memDqOutEn)}, {1'b1, 29'(~memByteN)});
        wrBe = ~memByteN;
        wrData = memDqOut;
      end else if (prevWr) begin
        check(wrCnt == WP, "R4", 32'(wrCnt), 32'(WP));
        begin
          logic [15:0] old;
          old = ramArr.exists(int'(wrAddr)) ? ramArr[int'(wrAddr)] : 16'h0000;
          for (int i = 0; i < 2; i++)
            if (wrBe[i]) old[i*8 +: 8] = wrData[i*8 +: 8];
          ramArr[int'(wrAddr)] = old;
        end
      end
      prevWr = wrCond;
    end
  end

  // Reference response model, compared every clock
  int          expCyc[$];
  logic [15:0] expDat[$];

  always @(negedge clk) begin
    if (rstN) begin
      if (expCyc.size() > 0 && expCyc[0] == cycCnt) begin
        check(rspValid == 1'b1, "R2 R9", 32'(rspValid), 32'd1);
        check(rspData == expDat[0], "R3", 32'(rspData), 32'(expDat[0]));
        void'(expCyc.pop_front());
        void'(expDat.pop_front());
      end else begin
        check(rspValid == 1'b0, "R9", 32'(rspValid), 32'd0);
      end
      if (reqReady)
        check(memCe1N && !memCe2 && memByteN == 2'b11 && memWeN && memOeN &&
              memDqOutEn == 2'b00, "R1",
              {26'd0, memCe1N, memCe2, memByteN, memWeN, memOeN},
              {26'd0, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1});
      else if (!memOeN)
        check(!memCe1N && memCe2 && memWeN, "R2",
              {29'd0, memCe1N, memCe2, memWeN}, {29'd0, 1'b0, 1'b1, 1'b1});
    end
  end

  task automatic doReq(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    int acc, busy;
    logic [15:0] cur, msk;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqByteEn = be;
    while (!reqReady) @(negedge clk);
    acc = cycCnt + 1;
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    msk = {{8{be[1]}}, {8{be[0]}}};
    if (wr) begin
      shadow[int'(a)] = (cur & ~msk) | (d & msk);
    end else begin
      expCyc.push_back(acc + RD);
      expDat.push_back(cur & msk);
    end
    @(negedge clk);
    reqValid = 0;
    busy = 0;
    while (!reqReady) begin
      busy++;
      @(negedge clk);
    end
    if (wr)
      check(busy * CLK_PERIOD >= T_CYC && busy >= WP + 2, "R8", 32'(busy), 32'(CYC));
    else
      check(busy == RD, "R8", 32'(busy), 32'(RD));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(memCe1N && memWeN && memOeN && memByteN == 2'b11 && !rspValid,
          "R1", {27'd0, memCe1N, memWeN, memOeN, memByteN}, 32'h1F);
    rstN = 1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", 32'(reqReady), 32'd1);

    // R2 R3: read of an unwritten word
    doReq(0, 18'h00005, 16'h0, 2'b11);
    // word write, readback
    doReq(1, 18'h00005, 16'h1234, 2'b11);
    doReq(0, 18'h00005, 16'h0, 2'b11);
    // R6: byte writes into the same word
    doReq(1, 18'h00005, 16'hFFAB, 2'b01);
    doReq(0, 18'h00005, 16'h0, 2'b11);
    doReq(1, 18'h00005, 16'hCD77, 2'b10);
    doReq(0, 18'h00005, 16'h0, 2'b11);
    // R3: lane reads
    doReq(0, 18'h00005, 16'h0, 2'b01);
    doReq(0, 18'h00005, 16'h0, 2'b10);
    // R7: read directly followed by a write
    doReq(0, 18'h00005, 16'h0, 2'b11);
    doReq(1, 18'h00006, 16'h5A5A, 2'b11);
    doReq(0, 18'h00006, 16'h0, 2'b11);
    // address and data extremes
    doReq(1, 18'h3FFFF, 16'hAAAA, 2'b11);
    doReq(1, 18'h00000, 16'h5555, 2'b11);
    doReq(0, 18'h3FFFF, 16'h0, 2'b11);
    doReq(0, 18'h00000, 16'h0, 2'b11);
    // pseudo-random mix
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 40; n++) begin
        logic [1:0]  be;
        logic [17:0] a;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        be = lfsr[5:4];
        if (be == 2'b00) be = 2'b11;
        a = {lfsr[3], 14'd0, lfsr[2:0]};
        doReq(lfsr[6], a, lfsr ^ 16'h3C96, be);
      end
    end
    repeat (10) @(negedge clk);
    check(expCyc.size() == 0, "R9", 32'(expCyc.size()), 32'd0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog R8: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule